// File: doc/BRIEF.md
# Clause-22 MDIO Management Frame Engine

This block runs single clause-22 management transactions toward an external PHY. Software writes one 32-bit command word that holds the start code, opcode, PHY address, register address, turnaround code and 16 data bits. If the management port is enabled and the word is a legal command, the engine starts at once. It sends a 32-bit preamble of ones followed by the 32 bits of the word. The bits go out MSB first on MDIO, one bit per MDC period. MDC is derived from the system clock by a divider picked from eight settings.

While a frame is in flight the `idle` flag is low. On a read, the engine releases MDIO for the turnaround and data bits. It samples the PHY's 16 data bits on the rising edges of MDC. When the frame ends they replace the low half of the command register. The upper half keeps the command. Software polls `idle` and then reads the register back.

Command word layout (bit 31 first on the wire): [31:30] start code, which must be 01; bit 30 is the clause-22 select bit. [29:28] opcode. [27:23] PHY address. [22:18] register address. [17:16] turnaround; software programs binary 10 for both reads and writes. [15:0] data.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset `idle` is 1, `mdc` is 0, `mdioOe` is 0 and `cmdRdData` is 0.
- R2: A command write is accepted only when all of these hold: `idle` is 1, `portEn` is 1, bits [31:30] are 01, and the opcode in [29:28] is 01 (write) or 10 (read). An accepted write stores the word in the register and starts a frame. Any other write leaves the register unchanged and starts no frame.
- R3: A frame is 64 MDC periods long. It carries 32 ones and then command bits 31 down to 0, MSB first. Each bit is set up while MDC is low and is stable across the MDC rising edge.
- R4: In a write frame (opcode 01), MDIO is driven for all 64 bits. The turnaround bits on the wire are the values in [17:16], and the data bits are [15:0].
- R5: In a read frame (opcode 10), MDIO is driven for frame bits 0 to 45, which run up to the end of the register address. It is released (`mdioOe` 0) for the two turnaround bits and the 16 data bits.
- R6: On a read, `mdioIn` is sampled at the MDC rising edge of frame bits 48 to 63. When the frame ends, [15:0] of the register holds those samples, first sample in bit 15, and [31:16] still holds the command.
- R7: `idle` falls in the cycle after the accepted write and stays low for exactly 64×D system clock cycles, where D is the MDC divisor.
- R8: `divSel` values 0 to 7 select D = 8, 16, 32, 48, 64, 96, 128, 224. Value 5 gives the system clock divided by 96. In each bit MDC is low for the first D/2 cycles and high for the rest. The setting is latched when a frame starts.
- R9: A command write while `idle` is 0 is ignored. The frame in flight and the register are not affected.
- R10: While `portEn` is 0 no frame starts. MDC does not toggle and the register keeps its value.
- R11: Whenever `idle` is 1, `mdc` is 0 and `mdioOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| portEn | input | 1 | Management port enable |
| divSel | input | 3 | MDC divisor select |
| cmdWrEn | input | 1 | Write strobe for the command register |
| cmdWrData | input | 32 | Command word |
| cmdRdData | output | 32 | Command register readback, with read data in [15:0] |
| idle | output | 1 | 1 when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value when driven |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value from the pad |

## Verification
The frame path is exercised with a mix of write and read commands. They use different PHY and register addresses and turnaround codes, and the PHY returns all-zero, all-one and mixed data. This separates a wrong field order, a stuck MDIO line and a wrong output-enable window from each other. Divisors of 8, 16 and 96 check the MDC period and the total busy time against the divisor. A bad divisor table shows up as a wrong period, and an off-by-one bit counter shows up as a wrong busy time. Commands that must be ignored are checked for an unchanged readback and no MDC activity: a write during a frame, writes with the port disabled, a bad start code and an illegal opcode.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam int         SEL_W      = 3;

  typedef struct packed {
    logic load;     // latch command, start frame
    logic shift;    // advance to next frame bit
    logic capture;  // sample mdioIn into read data
    logic drive;    // own the MDIO line this bit
  } mdioStrobe_t;

  function automatic int unsigned divisorOf(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 32;
      3'd3:    return 48;
      3'd4:    return 64;
      3'd5:    return 96;
      3'd6:    return 128;
      default: return 224;
    endcase
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             run,
  input  logic [SEL_W-1:0] divSel,
  output logic             mdc,
  output logic             riseTick,
  output logic             endTick
);

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] halfM1;
  logic [DIV_W-1:0] fullM1;

  assign halfM1   = (divReg >> 1) - DIV_W'(1);
  assign fullM1   = divReg - DIV_W'(1);
  assign riseTick = run && (cnt == halfM1);
  assign endTick  = run && (cnt == fullM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= DIV_W'(divisorOf('0));
      cnt    <= '0;
      mdc    <= 1'b0;
    end else if (load) begin
      divReg <= DIV_W'(divisorOf(divSel));
      cnt    <= '0;
      mdc    <= 1'b0;
    end else if (run) begin
      cnt <= endTick ? '0 : cnt + DIV_W'(1);
      if (riseTick)     mdc <= 1'b1;
      else if (endTick) mdc <= 1'b0;
    end else begin
      cnt <= '0;
      mdc <= 1'b0;
    end
  end

  // R8: a rise strobe is always followed by MDC high
  p_rise_sets_mdc_r8: assert property (@(posedge clk) disable iff (!rstN)
    riseTick |=> mdc);

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        portEn,
  input  logic        cmdWrEn,
  input  logic [3:0]  cmdHead,
  input  logic        riseTick,
  input  logic        endTick,
  output logic        busy,
  output mdioStrobe_t strobe
);

  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = PRE_BITS + 14;
  localparam int DATA_FIRST = PRE_BITS + 16;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic             isRead;
  logic [IDX_W-1:0] bitIdx;
  logic             legal;
  logic             accept;

  assign legal  = (cmdHead[3:2] == START_CODE) &&
                  ((cmdHead[1:0] == OP_WRITE) || (cmdHead[1:0] == OP_READ));
  assign accept = cmdWrEn && !busy && portEn && legal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      isRead <= 1'b0;
      bitIdx <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      isRead <= (cmdHead[1:0] == OP_READ);
      bitIdx <= '0;
    end else if (busy && endTick) begin
      if (bitIdx == LAST_IDX) busy <= 1'b0;
      else                    bitIdx <= bitIdx + IDX_W'(1);
    end
  end

  always_comb begin
    strobe.load    = accept;
    strobe.shift   = busy && endTick;
    strobe.capture = busy && isRead && riseTick &&
                     (int'(bitIdx) >= DATA_FIRST);
    strobe.drive   = busy && (!isRead || (int'(bitIdx) < TA_FIRST));
  end

  // R9: no new frame may start over a running one
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.load);

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobe_t strobe,
  input  logic [31:0] cmdWrData,
  input  logic        mdioIn,
  output logic [31:0] word,
  output logic        mdioOut,
  output logic        mdioOe
);

  localparam int FRAME_BITS = PRE_BITS + 32;

  logic [FRAME_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word     <= '0;
      shiftReg <= '0;
    end else if (strobe.load) begin
      word     <= cmdWrData;
      shiftReg <= {{PRE_BITS{1'b1}}, cmdWrData};
    end else begin
      if (strobe.shift)   shiftReg  <= {shiftReg[FRAME_BITS-2:0], 1'b0};
      if (strobe.capture) word[15:0] <= {word[14:0], mdioIn};
    end
  end

  assign mdioOe  = strobe.drive;
  assign mdioOut = strobe.drive & shiftReg[FRAME_BITS-1];

  // R5: data is only sampled while the line is released
  p_capture_released_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !mdioOe);
  // R6: capture never disturbs the command half
  p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.load) |=> $stable(word[31:16]));

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int DIV_W    = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        portEn,
  input  logic [2:0]  divSel,
  input  logic        cmdWrEn,
  input  logic [31:0] cmdWrData,
  output logic [31:0] cmdRdData,
  output logic        idle,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  mdioStrobe_t strobe;
  logic        busy;
  logic        riseTick;
  logic        endTick;

  mdio_ctrl #(.PRE_BITS(PRE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .cmdWrEn(cmdWrEn),
    .cmdHead(cmdWrData[31:28]), .riseTick(riseTick), .endTick(endTick),
    .busy(busy), .strobe(strobe)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rstN(rstN), .load(strobe.load), .run(busy),
    .divSel(divSel), .mdc(mdc), .riseTick(riseTick), .endTick(endTick)
  );

  mdio_datapath #(.PRE_BITS(PRE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdWrData(cmdWrData),
    .mdioIn(mdioIn), .word(cmdRdData), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  assign idle = !busy;

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> (!mdc && !mdioOe));
  p_frame_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idle) |-> (!mdc && mdioOe));
  p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && cmdWrEn) |=> $stable(cmdRdData[31:16]));
  p_port_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !portEn) |=> idle);

endmodule

// File: tb/mdio_mgmt_engine_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_engine_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        portEn = 1'b0;
  logic [2:0]  divSel = 3'd0;
  logic        cmdWrEn = 1'b0;
  logic [31:0] cmdWrData = '0;
  logic [31:0] cmdRdData;
  logic        idle, mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b0;

  int checks = 0;
  int failures = 0;
  int lowCnt = 0;
  int riseCnt = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  mdio_mgmt_engine u_mdio_mgmt_engine (
    .clk(clk), .rstN(rstN), .portEn(portEn), .divSel(divSel),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData), .cmdRdData(cmdRdData),
    .idle(idle), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  always @(negedge clk) if (rstN && !idle) lowCnt++;
  always @(posedge mdc) riseCnt++;

  // {divSel, command word, PHY reply}
  localparam int NV = 6;
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 2'b01, 2'b01, 5'd1,  5'd0,  2'b10, 16'h1234, 16'h0000},
    {3'd0, 2'b01, 2'b10, 5'd3,  5'd2,  2'b10, 16'h0000, 16'hBEEF},
    {3'd1, 2'b01, 2'b01, 5'd31, 5'd17, 2'b01, 16'hA5C3, 16'h0000},
    {3'd0, 2'b01, 2'b10, 5'd0,  5'd31, 2'b10, 16'hFFFF, 16'h0000},
    {3'd0, 2'b01, 2'b10, 5'd21, 5'd10, 2'b10, 16'h5555, 16'hFFFF},
    {3'd1, 2'b01, 2'b01, 5'd10, 5'd5,  2'b10, 16'h0001, 16'h8001}
  };

  function automatic int divOf(input logic [2:0] s);
    int t [8] = '{8, 16, 32, 48, 64, 96, 128, 224};
    return t[s];
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeCmd(input logic [31:0] w);
    @(negedge clk);
    cmdWrData = w;
    cmdWrEn = 1'b1;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  // Issue a command, act as the PHY, check wire bits, timing and readback
  task automatic runFrame(input logic [2:0] sel, input logic [31:0] w, input logic [15:0] phy);
    logic [63:0] expBits;
    bit isRd;
    int bitErr, oeErr, d;
    realtime t0, t1;
    expBits = {32'hFFFF_FFFF, w};
    isRd = (w[29:28] == 2'b10);
    d = divOf(sel);
    bitErr = 0; oeErr = 0;
    divSel = sel;
    lowCnt = 0;
    writeCmd(w);
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      if (k == 0) t0 = $realtime;
      if (k == 1) t1 = $realtime;
      #1;
      if (mdioOe !== ((!isRd) || (k < 46))) oeErr++;
      if (mdioOe && (mdioOut !== expBits[63-k])) bitErr++;
      if (isRd && k >= 47 && k <= 62) mdioIn = phy[62-k];
    end
    while (!idle) @(negedge clk);
    mdioIn = 1'b0;
    check(bitErr == 0, "R3/R4 wire bits", bitErr, 0);
    check(oeErr == 0, "R5 output enable window", oeErr, 0);
    check(lowCnt == 64*d, "R7 busy duration", lowCnt, 64*d);
    check((t1 - t0) == 4.0*d, "R8 MDC period", longint'(t1 - t0), longint'(4*d));
    check(cmdRdData == (isRd ? {w[31:16], phy} : w), "R6 readback",
          cmdRdData, isRd ? {w[31:16], phy} : w);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    int r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(idle === 1'b1 && mdc === 1'b0 && mdioOe === 1'b0, "R1 reset outputs",
          {idle, mdc, mdioOe}, 3'b100);
    check(cmdRdData === 32'h0, "R1 reset register", cmdRdData, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10: port disabled, legal write ignored
    r0 = riseCnt;
    writeCmd({2'b01, 2'b01, 5'd1, 5'd1, 2'b10, 16'hCAFE});
    repeat (40) @(negedge clk);
    check(idle && riseCnt == r0 && cmdRdData == 0, "R10 port disabled ignored",
          cmdRdData, 0);
    portEn = 1'b1;

    // R2/R3/R4/R5/R6/R7 table walk
    for (int i = 0; i < NV; i++)
      runFrame(VEC[i][50:48], VEC[i][47:16], VEC[i][15:0]);

    // R2: bad start code and illegal opcode are ignored
    keep = cmdRdData;
    r0 = riseCnt;
    writeCmd({2'b00, 2'b01, 5'd2, 5'd2, 2'b10, 16'h1111});
    repeat (40) @(negedge clk);
    check(idle && riseCnt == r0 && cmdRdData == keep, "R2 bad start ignored", cmdRdData, keep);
    writeCmd({2'b01, 2'b11, 5'd2, 5'd2, 2'b10, 16'h2222});
    repeat (40) @(negedge clk);
    check(idle && riseCnt == r0 && cmdRdData == keep, "R2 bad opcode ignored", cmdRdData, keep);

    // R9: write during a frame ignored
    divSel = 3'd0;
    lowCnt = 0;
    writeCmd({2'b01, 2'b01, 5'd4, 5'd4, 2'b10, 16'h4444});
    repeat (30) @(negedge clk);
    writeCmd({2'b01, 2'b10, 5'd7, 5'd7, 2'b10, 16'h7777});
    while (!idle) @(negedge clk);
    check(cmdRdData == {2'b01, 2'b01, 5'd4, 5'd4, 2'b10, 16'h4444}, "R9 busy write ignored",
          cmdRdData, {2'b01, 2'b01, 5'd4, 5'd4, 2'b10, 16'h4444});
    check(lowCnt == 512, "R9 frame length unchanged", lowCnt, 512);

    // R8: divide by 96 read frame
    runFrame(3'd5, {2'b01, 2'b10, 5'd9, 5'd1, 2'b10, 16'h0000}, 16'h6C39);

    // R11 quiet after frame
    repeat (5) @(negedge clk);
    check(idle && !mdc && !mdioOe, "R11 idle quiet", {idle, mdc, mdioOe}, 3'b100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule